// File: doc/BRIEF.md
# Three-Operand Integer Adder Slice

This block is one slice of an integer datapath that sums three 32-bit operands in a single operation. Before any addition, each operand may be cut down to one zero-extended 16-bit half and may be replaced by its two's-complement negation. The first two operands are added together. A stored carry flag can be folded into that sum as an extra 0 or 1. The resulting partial sum can then be moved by sixteen bit positions in either direction, and the third operand is added to it.

The result is captured in an output register on each cycle where the input strobe is high. The unit can optionally update four condition flags: zero, sign, carry and overflow. Some control combinations have no defined meaning, and reserved codes exist. The unit reports all of these on a registered indication so the surrounding pipeline can trap them. The block does not fetch operands or decode instructions. The caller supplies operand values and decoded control bits.

Top module: `tadd3_unit`

## Requirements
- R1: Each operand has a 2-bit half code: 0 passes the full 32 bits, 1 selects bits 15:0 zero-extended, 2 selects bits 31:16 zero-extended.
- R2: Each operand has its own negate bit; when set, the operand after half selection is replaced by its 32-bit two's-complement negation before any addition.
- R3: The partial sum is operand A plus operand B, plus `carry_in` (0 or 1) when `use_carry` is 1, taken modulo 2^32.
- R4: The shift code acts on the partial sum: 0 leaves it unchanged, 1 shifts it logically right by 16, 2 shifts it logically left by 16; the result is the shifted value plus operand C, modulo 2^32.
- R5: With shift code 1, if the first addition carried out of bit 31, 0x10000 is added to the right-shifted value, so the shift acts as a 33-bit shift.
- R6: On an accepted operation with `flag_en` = 1 and no unsupported condition, `flag_z` is set if and only if the result is zero, `flag_s` takes result bit 31, and `flag_c` takes the carry out of the final addition.
- R7: In that case `flag_o` is the signed overflow of the final addition ORed with (partial sum before shifting, unsigned, is less than the prepared operand A).
- R8: `unsupported` is captured as 1 when `use_carry` is combined with shift code 1, when `use_carry` is combined with `flag_en`, when any half code is 3, or when the shift code is 3. Code 3 leaves the operand or the partial sum unchanged, and the result is still written.
- R9: The four flags keep their previous values when `flag_en` is 0, when the operation is unsupported, or when `in_valid` is 0.
- R10: `result` and `unsupported` are loaded only on a clock edge with `in_valid` high and hold otherwise; `out_valid` equals `in_valid` from the previous edge.
- R11: A synchronous active-low reset (`rst_n` = 0 at a clock edge) clears `result`, all four flags, `unsupported` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Third operand |
| half_a | input | 2 | Half code for operand A |
| half_b | input | 2 | Half code for operand B |
| half_c | input | 2 | Half code for operand C |
| neg_a | input | 1 | Negate operand A |
| neg_b | input | 1 | Negate operand B |
| neg_c | input | 1 | Negate operand C |
| use_carry | input | 1 | Add carry_in into the partial sum |
| carry_in | input | 1 | Current stored carry flag |
| shift_sel | input | 2 | Shift code for the partial sum |
| flag_en | input | 1 | Update condition flags |
| out_valid | output | 1 | Result was loaded on the previous edge |
| result | output | 32 | Registered sum |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry flag |
| flag_o | output | 1 | Overflow flag |
| unsupported | output | 1 | Captured operation used an undefined combination |

## Verification
The hardest case to reach is the 33-bit right-shift correction. It needs operands A and B to carry out of bit 31, and the low half of their sum must not hide the correction. Random operands seldom meet both conditions with the right shift selected. Directed scenarios therefore pair values such as 0xFFFF0000 and 0x00020000, and also use negated small operands, whose sum always wraps. The partial-stage overflow term is reached the same way, with sums that wrap below operand A. A reference model in the bench uses 64-bit arithmetic. It predicts every result. It also tracks the flags across operations that are expected to leave them untouched.

// File: rtl/tadd3_pkg.sv
// Package: shared encodings for the three-operand adder slice.
// Assumes 2-bit control codes as fixed by the decoder feeding the slice.
package tadd3_pkg;

    typedef enum logic [1:0] {
        HSEL_FULL = 2'd0,
        HSEL_LOW  = 2'd1,
        HSEL_HIGH = 2'd2,
        HSEL_RSV  = 2'd3
    } hsel_e;

    typedef enum logic [1:0] {
        PSH_NONE  = 2'd0,
        PSH_RIGHT = 2'd1,
        PSH_LEFT  = 2'd2,
        PSH_RSV   = 2'd3
    } psh_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic o;
    } cond_flags_t;

    localparam int unsigned NUM_OPS = 3;

endpackage

// File: rtl/tadd3_operand_prep.sv
// Module: operand preparation. Selects the full word or one zero-extended
// half, then optionally negates in two's complement.
// Assumes W is even; the reserved code passes the word unchanged and raises rsv.
module tadd3_operand_prep
    import tadd3_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] val_in,
    input  logic [1:0]   hcode,
    input  logic         negate,
    output logic [W-1:0] val_out,
    output logic         rsv
);
    localparam int unsigned HW = W / 2;

    logic [W-1:0] picked;
    hsel_e        sel;

    assign sel = hsel_e'(hcode);

    // Pick the requested portion of the operand.
    always_comb begin
        rsv = 1'b0;
        unique case (sel)
            HSEL_FULL: picked = val_in;
            HSEL_LOW:  picked = {{HW{1'b0}}, val_in[HW-1:0]};
            HSEL_HIGH: picked = {{HW{1'b0}}, val_in[W-1:HW]};
            default: begin
                picked = val_in;
                rsv    = 1'b1;
            end
        endcase
    end

    // Apply the optional two's-complement negation.
    always_comb begin
        if (negate) val_out = (~picked) + {{(W-1){1'b0}}, 1'b1};
        else        val_out = picked;
    end

endmodule

// File: rtl/tadd3_partial.sv
// Module: first-stage adder and partial-sum shifter. Adds A and B with an
// optional carry-in, then shifts by half a word, applying the 33-bit
// correction on a right shift when the first addition carried out.
// Assumes operands already prepared; reserved shift code passes unchanged.
module tadd3_partial
    import tadd3_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin_en,
    input  logic         cin,
    input  logic [1:0]   scode,
    output logic [W-1:0] psum,
    output logic [W-1:0] shifted,
    output logic         part_below_a,
    output logic         rsv
);
    localparam int unsigned HW = W / 2;
    localparam logic [W-1:0] HALF_ONE = {{(HW-1){1'b0}}, 1'b1, {HW{1'b0}}};

    logic [W:0] wide_sum;
    logic       carry1;
    psh_e       sh;

    assign sh = psh_e'(scode);

    // Widened first addition to expose the carry out.
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (cin_en & cin)};
        psum     = wide_sum[W-1:0];
        carry1   = wide_sum[W];
    end

    // Unsigned comparison feeding the merged overflow flag.
    always_comb begin
        part_below_a = (psum < a);
    end

    // Shift the partial sum by half a word.
    always_comb begin
        rsv = 1'b0;
        unique case (sh)
            PSH_NONE:  shifted = psum;
            PSH_RIGHT: shifted = (psum >> HW) + (carry1 ? HALF_ONE : '0);
            PSH_LEFT:  shifted = psum << HW;
            default: begin
                shifted = psum;
                rsv     = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tadd3_final.sv
// Module: second-stage adder producing the sum and its raw condition bits.
// Assumes both inputs are already in final form.
module tadd3_final
    import tadd3_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   sum,
    output cond_flags_t    raw
);
    logic [W:0] wide;

    // Final addition, widened for carry out.
    always_comb begin
        wide = {1'b0, lhs} + {1'b0, rhs};
        sum  = wide[W-1:0];
    end

    // Derive zero, sign, carry and signed overflow of the final addition.
    always_comb begin
        raw.z = (sum == '0);
        raw.s = sum[W-1];
        raw.c = wide[W];
        raw.o = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);
    end

endmodule

// File: rtl/tadd3_unit.sv
// Module: top of the three-operand adder slice. Prepares three operands,
// forms and shifts the partial sum, adds the third operand and registers
// result, flags and the unsupported indication on an accepted strobe.
// Assumes a synchronous active-low reset and one operation per strobe.
module tadd3_unit
    import tadd3_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [31:0]  opnd_a,
    input  logic [31:0]  opnd_b,
    input  logic [31:0]  opnd_c,
    input  logic [1:0]   half_a,
    input  logic [1:0]   half_b,
    input  logic [1:0]   half_c,
    input  logic         neg_a,
    input  logic         neg_b,
    input  logic         neg_c,
    input  logic         use_carry,
    input  logic         carry_in,
    input  logic [1:0]   shift_sel,
    input  logic         flag_en,
    output logic         out_valid,
    output logic [31:0]  result,
    output logic         flag_z,
    output logic         flag_s,
    output logic         flag_c,
    output logic         flag_o,
    output logic         unsupported
);
    logic [W-1:0] raw_ops  [NUM_OPS];
    logic [1:0]   hcodes   [NUM_OPS];
    logic         negs     [NUM_OPS];
    logic [W-1:0] prep_ops [NUM_OPS];
    logic [NUM_OPS-1:0] half_rsv;

    logic [W-1:0] psum, shifted, sum;
    logic         below_a, shift_rsv, combo_bad, unsup_now;
    cond_flags_t  raw, flags_q;

    // Gather per-operand inputs into arrays for the generate loop.
    always_comb begin
        raw_ops[0] = opnd_a; raw_ops[1] = opnd_b; raw_ops[2] = opnd_c;
        hcodes[0]  = half_a; hcodes[1]  = half_b; hcodes[2]  = half_c;
        negs[0]    = neg_a;  negs[1]    = neg_b;  negs[2]    = neg_c;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_prep
        tadd3_operand_prep #(.W(W)) u_prep (
            .val_in  (raw_ops[i]),
            .hcode   (hcodes[i]),
            .negate  (negs[i]),
            .val_out (prep_ops[i]),
            .rsv     (half_rsv[i])
        );
    end

    tadd3_partial #(.W(W)) u_part (
        .a            (prep_ops[0]),
        .b            (prep_ops[1]),
        .cin_en       (use_carry),
        .cin          (carry_in),
        .scode        (shift_sel),
        .psum         (psum),
        .shifted      (shifted),
        .part_below_a (below_a),
        .rsv          (shift_rsv)
    );

    tadd3_final #(.W(W)) u_fin (
        .lhs (shifted),
        .rhs (prep_ops[2]),
        .sum (sum),
        .raw (raw)
    );

    // Detect undefined control combinations and reserved codes.
    always_comb begin
        combo_bad = use_carry && ((psh_e'(shift_sel) == PSH_RIGHT) || flag_en);
        unsup_now = combo_bad || (|half_rsv) || shift_rsv;
    end

    // Result, unsupported and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            unsupported <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= sum;
                unsupported <= unsup_now;
            end
        end
    end

    // Condition flag registers, updated only on a supported flag-writing op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (in_valid && flag_en && !unsup_now) begin
            flags_q.z <= raw.z;
            flags_q.s <= raw.s;
            flags_q.c <= raw.c;
            flags_q.o <= raw.o | below_a;
        end
    end

    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_c = flags_q.c;
    assign flag_o = flags_q.o;

    logic unused_psum;
    assign unused_psum = ^psum;

endmodule

// File: rtl/tadd3_unit_chk.sv
// Module: temporal checks on the adder slice ports, attached by bind.
// Assumes the same clock and active-low reset as the unit.
module tadd3_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  half_a,
    input logic [1:0]  half_b,
    input logic [1:0]  half_c,
    input logic        use_carry,
    input logic [1:0]  shift_sel,
    input logic        flag_en,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_z,
    input logic        flag_s,
    input logic        flag_c,
    input logic        flag_o,
    input logic        unsupported
);
    logic clean_op;
    assign clean_op = !use_carry && (half_a != 2'd3) && (half_b != 2'd3)
                      && (half_c != 2'd3) && (shift_sel != 2'd3);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(unsupported));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !flag_en) |=> $stable({flag_z, flag_s, flag_c, flag_o}));

    // R8
    carry_flag_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_carry && flag_en) |=> unsupported);

    // R6
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_en && clean_op) |=>
            (flag_z == (result == 32'd0)) && (flag_s == result[31]));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 32'd0 && !unsupported
                    && !flag_z && !flag_s && !flag_c && !flag_o));

endmodule

bind tadd3_unit tadd3_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .half_a      (half_a),
    .half_b      (half_b),
    .half_c      (half_c),
    .use_carry   (use_carry),
    .shift_sel   (shift_sel),
    .flag_en     (flag_en),
    .out_valid   (out_valid),
    .result      (result),
    .flag_z      (flag_z),
    .flag_s      (flag_s),
    .flag_c      (flag_c),
    .flag_o      (flag_o),
    .unsupported (unsupported)
);

// File: tb/tadd3_unit_test.sv
module tadd3_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a = '0, b = '0, c = '0;
    logic [1:0]  ha = '0, hb = '0, hc = '0, sh = '0;
    logic        na = 0, nb = 0, nc = 0, uc = 0, cf = 0, fe = 0;
    logic        out_valid, flag_z, flag_s, flag_c, flag_o, unsupported;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_flags = 4'b0;   // {z,s,c,o}
    logic [31:0] exp_res = '0;
    logic exp_uns = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    tadd3_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(a), .opnd_b(b), .opnd_c(c),
        .half_a(ha), .half_b(hb), .half_c(hc),
        .neg_a(na), .neg_b(nb), .neg_c(nc),
        .use_carry(uc), .carry_in(cf), .shift_sel(sh), .flag_en(fe),
        .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_o(flag_o),
        .unsupported(unsupported)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] prep(input logic [31:0] v, input logic [1:0] h,
                                         input logic n);
        logic [63:0] p;
        case (h)
            2'd1: p = {48'd0, v[15:0]};
            2'd2: p = {48'd0, v[31:16]};
            default: p = {32'd0, v};
        endcase
        if (n) p = (64'h1_0000_0000 - p) & 64'hFFFF_FFFF;
        return p;
    endfunction

    // Reference model in 64-bit arithmetic; updates expectations.
    task automatic model();
        logic [63:0] pa, pb, pc, s1, l1, l2, s2;
        logic ov, uns;
        pa = prep(a, ha, na);
        pb = prep(b, hb, nb);
        pc = prep(c, hc, nc);
        s1 = pa + pb + ((uc && cf) ? 64'd1 : 64'd0);
        l1 = s1 & 64'hFFFF_FFFF;
        case (sh)
            2'd1: l2 = (l1 >> 16) + (s1[32] ? 64'h1_0000 : 64'd0);
            2'd2: l2 = (l1 << 16) & 64'hFFFF_FFFF;
            default: l2 = l1;
        endcase
        s2 = l2 + pc;
        ov = (l2[31] == pc[31]) && (s2[31] != l2[31]);
        uns = (uc && (sh == 2'd1 || fe)) || ha == 2'd3 || hb == 2'd3
              || hc == 2'd3 || sh == 2'd3;
        exp_res = s2[31:0];
        exp_uns = uns;
        if (fe && !uns)
            exp_flags = {(s2[31:0] == 32'd0), s2[31], s2[32], ov | (l1 < pa)};
    endtask

    task automatic set_op(input logic [31:0] ia, ib, ic, input logic [1:0] iha, ihb, ihc,
                          input logic ina, inb, inc, iuc, icf, input logic [1:0] ish,
                          input logic ife);
        a = ia; b = ib; c = ic; ha = iha; hb = ihb; hc = ihc;
        na = ina; nb = inb; nc = inc; uc = iuc; cf = icf; sh = ish; fe = ife;
    endtask

    // Issue one operation and check every output against the model.
    task automatic run_op(input string req);
        @(negedge clk);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "result", result, exp_res);
        chk(req, "unsupported", {31'd0, unsupported}, {31'd0, exp_uns});
        chk(req, "flags zsco", {28'd0, flag_z, flag_s, flag_c, flag_o}, {28'd0, exp_flags});
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R11", "result after reset", result, 32'd0);
        chk("R11", "flags after reset", {28'd0, flag_z, flag_s, flag_c, flag_o}, 32'd0);
        chk("R11", "valid/unsup after reset", {30'd0, out_valid, unsupported}, 32'd0);
    endtask

    task automatic t_halves();
        for (int h = 0; h < 3; h++)
            for (int k = 0; k < 3; k++) begin
                set_op(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, h[1:0], k[1:0],
                       2'(2 - k), 0, 0, 0, 0, 0, 2'd0, 1);
                run_op("R1");
            end
    endtask

    task automatic t_negate();
        for (int m = 0; m < 8; m++) begin
            set_op(32'd100, 32'd7, 32'h8000_0000, 2'd0, 2'd1, 2'd0,
                   m[0], m[1], m[2], 0, 0, 2'd0, 1);
            run_op("R2");
        end
        set_op(32'd0, 32'd0, 32'd0, 2'd0, 2'd0, 2'd0, 1, 1, 1, 0, 0, 2'd0, 1);
        run_op("R2");
    endtask

    task automatic t_carry_in();
        set_op(32'hFFFF_FFFE, 32'd1, 32'd5, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1, 1, 2'd0, 0);
        run_op("R3");
        set_op(32'hFFFF_FFFE, 32'd1, 32'd5, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1, 0, 2'd2, 0);
        run_op("R3");
        set_op(32'hFFFF_FFFE, 32'd1, 32'd5, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 1, 2'd0, 1);
        run_op("R3");
    endtask

    task automatic t_shifts();
        for (int s = 0; s < 3; s++) begin
            set_op(32'h0012_3456, 32'h0000_1111, 32'h0000_0001, 2'd0, 2'd0, 2'd0,
                   0, 0, 0, 0, 0, s[1:0], 1);
            run_op("R4");
        end
    endtask

    task automatic t_rshift_fix();
        set_op(32'hFFFF_0000, 32'h0002_0000, 32'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd1, 1);
        run_op("R5");
        chk("R5", "33-bit shift value", result, 32'h0001_0001);
        set_op(32'd3, 32'd5, 32'd0, 2'd0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 2'd1, 1);
        run_op("R5");
        chk("R5", "negated sum shift", result, 32'h0001_FFFF);
        set_op(32'h8000_0000, 32'h8000_0000, 32'h1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd1, 1);
        run_op("R5");
    endtask

    task automatic t_flags();
        set_op(32'd5, 32'd5, 32'd0, 2'd0, 2'd0, 2'd0, 0, 1, 0, 0, 0, 2'd0, 1);
        run_op("R6");
        chk("R6", "zero flag set", {31'd0, flag_z}, 32'd1);
        set_op(32'hFFFF_FFFF, 32'd0, 32'd1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R6");
        chk("R6", "carry flag set", {31'd0, flag_c}, 32'd1);
    endtask

    task automatic t_overflow();
        set_op(32'h7FFF_FFFF, 32'd0, 32'd1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R7");
        chk("R7", "final-stage overflow", {31'd0, flag_o}, 32'd1);
        set_op(32'hFFFF_FFFF, 32'd1, 32'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R7");
        chk("R7", "partial-stage overflow", {31'd0, flag_o}, 32'd1);
        set_op(32'd1, 32'd2, 32'd3, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R7");
        chk("R7", "no overflow", {31'd0, flag_o}, 32'd0);
    endtask

    task automatic t_unsupported();
        set_op(32'h1, 32'h2, 32'h3, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1, 1, 2'd1, 0);
        run_op("R8");
        set_op(32'hFFFF_FFFF, 32'h1, 32'h0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1, 1, 2'd0, 1);
        run_op("R8");
        set_op(32'hABCD_1234, 32'h1, 32'h0, 2'd3, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R8");
        set_op(32'h1, 32'hABCD_1234, 32'h0, 2'd0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 2'd0, 0);
        run_op("R8");
        set_op(32'h1, 32'h1, 32'hABCD_1234, 2'd0, 2'd0, 2'd3, 0, 0, 0, 0, 0, 2'd0, 0);
        run_op("R8");
        set_op(32'h0001_0000, 32'h2, 32'h0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd3, 1);
        run_op("R8");
        set_op(32'h1, 32'h1, 32'h1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 0);
        run_op("R8");
    endtask

    task automatic t_hold();
        set_op(32'h7FFF_FFFF, 32'd0, 32'd1, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R9");
        set_op(32'd0, 32'd0, 32'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 0);
        run_op("R9");
        set_op(32'h1111, 32'h2222, 32'h3333, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        repeat (3) @(negedge clk);
        chk("R10", "result held while idle", result, exp_res);
        chk("R9", "flags held while idle", {28'd0, flag_z, flag_s, flag_c, flag_o},
            {28'd0, exp_flags});
        chk("R10", "out_valid low while idle", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            set_op($urandom, $urandom, $urandom, 2'($urandom % 3), 2'($urandom % 3),
                   2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 2'($urandom % 3), 1'($urandom));
            run_op("R4");
        end
    endtask

    task automatic t_midrun_reset();
        set_op(32'h8000_0000, 32'h8000_0000, 32'h0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 2'd0, 1);
        run_op("R11");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        exp_flags = 4'b0;
        t_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halves();
        t_negate();
        t_carry_in();
        t_shifts();
        t_rshift_fix();
        t_flags();
        t_overflow();
        t_unsupported();
        t_hold();
        t_random();
        t_midrun_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule